// File: doc/BRIEF.md
# Quad-I/O Serial Flash Read Engine

This block sits on the host side of a serial NOR flash and fetches bytes from it with the four-line fast read transaction. A client hands it a 24-bit start address and a byte count. The engine then drives chip select, the serial clock and four data lines through a frame with these phases: an optional opcode, the address, a mode byte and dummy clocks. After that it gathers the returned nibbles into bytes and presents them on a valid/ready stream. The flash steps its own address forward after every byte, so one request can read a run of any length from any start address.

The engine remembers whether the mode byte it last sent put the flash into continuous read mode. While that is the case, the next request starts directly with the address and drops the eight opcode clocks. The client chooses per request whether to stay in that mode. A separate mode-reset request drives all four lines high for eight clocks so that the flash leaves the mode, and afterwards the engine sends the opcode again. The serial clock runs at half the system clock. It pauses with the clock low whenever a finished byte is still waiting for the consumer, so no byte is ever lost.

Top module: `qspi_quad_reader`

## Requirements
- R1: After reset, cs_n is high, sclk is low, io_oe is 0, out_valid is 0 and req_ready is 1.
- R2: When the flash is not in continuous mode, a read frame begins with opcode 0xEB. It is sent one bit per sclk clock on io line 0, most significant bit first, for eight clocks, with io_oe = 4'b0001.
- R3: The 24-bit address follows in six clocks, four bits per clock, most significant byte first. In each byte the upper nibble goes first, and within a nibble io line 3 carries the highest bit. All four lines are driven (io_oe = 4'hF).
- R4: Two clocks after the address carry the mode byte in the same bit order. It is 0xA0 when req_stay was 1 at acceptance and 0x00 otherwise.
- R5: A read frame that follows a frame whose mode byte had upper nibble 0xA has no opcode and starts with the address. After any other mode byte, the next read frame carries the opcode.
- R6: Four dummy clocks follow the mode byte. io_oe is 0 from the first dummy clock until cs_n rises. Read data is sampled on rising sclk edges, upper nibble first, with io line 3 as the highest bit.
- R7: A request returns req_len+1 bytes in order, taken from consecutive addresses starting at req_addr. The frame lasts exactly (opcode clocks) + 12 + 2·(req_len+1) sclk clocks.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold. The engine pauses sclk low rather than overwrite a waiting byte.
- R9: A mode-reset request produces a frame of exactly eight sclk clocks with all four lines driven high. Afterwards the next read frame carries the opcode.
- R10: Between frames cs_n stays high for at least two system clock cycles (one sclk period), and sclk is low whenever cs_n is high.
- R11: req_ready is high only while no frame is in progress. When mrst_valid and req_valid are both high, the mode reset is taken first and the read is taken after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Number of bytes minus one |
| req_stay | input | 1 | 1: send mode 0xA0 and stay in continuous mode; 0: send 0x00 |
| mrst_valid | input | 1 | Mode-reset request, priority over a read |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, half the system clock rate |
| io_o | output | 4 | Values driven on data lines 3..0 |
| io_oe | output | 4 | Per-line output enable |
| io_i | input | 4 | Values seen on data lines 3..0 |

## Verification
The hardest situation to reach is a chain of frames whose format depends on the history of mode bytes. Examples are a read that leaves continuous mode while skipping the opcode, and a mode reset that arrives while the flash is in continuous mode and so looks like address and mode nibbles of all ones. The bench's flash model tracks its own continuous state only from the mode nibbles it decodes, and the stimulus walks it through stay, stay, leave, leave, reset-in-mode and a simultaneous reset-plus-read. A slow consumer pattern then forces sclk to pause in the middle of a multi-byte read.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

    localparam logic [7:0] OPC_QIO_READ = 8'hEB;
    localparam logic [7:0] MODE_STAY    = 8'hA0;
    localparam logic [7:0] MODE_LEAVE   = 8'h00;

    localparam int CMD_CLKS = 8;
    localparam int ADR_CLKS = 8;   // six address clocks plus two mode clocks
    localparam int DUM_CLKS = 4;
    localparam int RST_CLKS = 8;
    localparam int GAP_CYC  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADR,
        ST_DUM,
        ST_DATA,
        ST_MRST,
        ST_GAP
    } seq_st_e;

    typedef struct packed {
        logic [23:0] addr;
        logic [7:0]  mode;
    } adr_frame_t;

    function automatic logic [7:0] mode_byte(input logic stay);
        return stay ? MODE_STAY : MODE_LEAVE;
    endfunction

    function automatic logic [3:0] oe_for(input seq_st_e st);
        logic [3:0] oe;
        case (st)
            ST_CMD:          oe = 4'b0001;
            ST_ADR, ST_MRST: oe = 4'b1111;
            default:         oe = 4'b0000;
        endcase
        return oe;
    endfunction

endpackage

// File: rtl/qspi_rx_buf.sv
module qspi_rx_buf (
    input  logic       clk,
    input  logic       rst,
    input  logic       cap_hi,
    input  logic       cap_lo,
    input  logic [3:0] io_i,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       hold
);
    logic [3:0] hi_q;

    assign hold = out_valid && !out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (cap_hi) begin
                hi_q <= io_i;
            end
            if (cap_lo) begin
                out_data  <= {hi_q, io_i};
                out_valid <= 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/qspi_frame_seq.sv
module qspi_frame_seq
    import qspi_rd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_stay,
    input  logic             mrst_valid,
    input  logic             hold,
    output logic             req_ready,
    output logic             cs_n,
    output logic             sclk,
    output logic [3:0]       io_o,
    output logic [3:0]       io_oe,
    output logic             cap_hi,
    output logic             cap_lo
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_CLKS - 1);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_CLKS - 1);
    localparam logic [CNT_W-1:0] DUM_LAST = CNT_W'(DUM_CLKS - 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CLKS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

    seq_st_e          st;
    logic             sclk_q;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       op_sh;
    logic [31:0]      am_sh;
    logic [LEN_W-1:0] rem;
    logic             nib;
    logic             last;
    logic             cont;
    logic             stay_q;
    logic             cap_en;
    adr_frame_t       load_fr;

    assign load_fr   = '{addr: req_addr, mode: mode_byte(req_stay)};
    assign req_ready = (st == ST_IDLE);
    assign sclk      = sclk_q;
    assign cap_en    = (st == ST_DATA) && !sclk_q && !hold;
    assign cap_hi    = cap_en && !nib;
    assign cap_lo    = cap_en && nib;
    assign io_oe     = oe_for(st);

    always_comb begin
        io_o = '0;
        case (st)
            ST_CMD:  io_o = {3'b000, op_sh[7]};
            ST_ADR:  io_o = am_sh[31:28];
            ST_MRST: io_o = 4'hF;
            default: io_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cs_n   <= 1'b1;
            sclk_q <= 1'b0;
            cnt    <= '0;
            op_sh  <= '0;
            am_sh  <= '0;
            rem    <= '0;
            nib    <= 1'b0;
            last   <= 1'b0;
            cont   <= 1'b0;
            stay_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (mrst_valid) begin
                        st   <= ST_MRST;
                        cs_n <= 1'b0;
                        cnt  <= RST_LAST;
                    end else if (req_valid) begin
                        cs_n   <= 1'b0;
                        op_sh  <= OPC_QIO_READ;
                        am_sh  <= load_fr;
                        stay_q <= req_stay;
                        rem    <= req_len;
                        nib    <= 1'b0;
                        last   <= 1'b0;
                        st     <= cont ? ST_ADR : ST_CMD;
                        cnt    <= cont ? ADR_LAST : CMD_LAST;
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: begin
                    if (!sclk_q) begin
                        // rising half: flash and engine both sample here
                        if (!(st == ST_DATA && hold)) begin
                            sclk_q <= 1'b1;
                            if (st == ST_DATA) begin
                                nib <= ~nib;
                                if (nib) begin
                                    last <= (rem == '0);
                                    if (rem != '0) rem <= rem - 1'b1;
                                end
                            end
                        end
                    end else begin
                        // falling half: present the next bit or move on
                        sclk_q <= 1'b0;
                        case (st)
                            ST_CMD: begin
                                op_sh <= op_sh << 1;
                                if (cnt == '0) begin
                                    st  <= ST_ADR;
                                    cnt <= ADR_LAST;
                                end else begin
                                    cnt <= cnt - 1'b1;
                                end
                            end
                            ST_ADR: begin
                                am_sh <= am_sh << 4;
                                if (cnt == '0) begin
                                    st   <= ST_DUM;
                                    cnt  <= DUM_LAST;
                                    cont <= stay_q;
                                end else begin
                                    cnt <= cnt - 1'b1;
                                end
                            end
                            ST_DUM: begin
                                if (cnt == '0) st <= ST_DATA;
                                else           cnt <= cnt - 1'b1;
                            end
                            ST_DATA: begin
                                if (!nib && last) begin
                                    st   <= ST_GAP;
                                    cs_n <= 1'b1;
                                    cnt  <= GAP_LAST;
                                end
                            end
                            ST_MRST: begin
                                if (cnt == '0) begin
                                    st   <= ST_GAP;
                                    cs_n <= 1'b1;
                                    cnt  <= GAP_LAST;
                                    cont <= 1'b0;
                                end else begin
                                    cnt <= cnt - 1'b1;
                                end
                            end
                            default: st <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader
    import qspi_rd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_stay,
    input  logic             mrst_valid,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             cs_n,
    output logic             sclk,
    output logic [3:0]       io_o,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_i
);
    logic hold;
    logic cap_hi;
    logic cap_lo;

    qspi_frame_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_stay   (req_stay),
        .mrst_valid (mrst_valid),
        .hold       (hold),
        .req_ready  (req_ready),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .io_o       (io_o),
        .io_oe      (io_oe),
        .cap_hi     (cap_hi),
        .cap_lo     (cap_lo)
    );

    qspi_rx_buf u_rx (
        .clk       (clk),
        .rst       (rst),
        .cap_hi    (cap_hi),
        .cap_lo    (cap_lo),
        .io_i      (io_i),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .hold      (hold)
    );
endmodule

// File: rtl/qspi_quad_reader_chk.sv
module qspi_quad_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       cs_n,
    input logic       sclk,
    input logic [3:0] io_oe
);
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_sclk_low_idle_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

    p_release_lines_r6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'h0));

    p_oe_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 4'h0) || (io_oe == 4'h1) || (io_oe == 4'hF));

    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> !req_ready);
endmodule

bind qspi_quad_reader qspi_quad_reader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .io_oe     (io_oe)
);

// File: tb/sim_qspi_quad_reader.sv
module sim_qspi_quad_reader;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_stay = 1'b0;
    logic             mrst_valid = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_data;
    logic             cs_n;
    logic             sclk;
    logic [3:0]       io_o;
    logic [3:0]       io_oe;
    logic [3:0]       io_in = '0;

    always #10 clk = ~clk;   // 50 MHz

    qspi_quad_reader #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_stay(req_stay),
        .mrst_valid(mrst_valid), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .cs_n(cs_n), .sclk(sclk), .io_o(io_o),
        .io_oe(io_oe), .io_i(io_in)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int stalls = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fdat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
    endfunction

    typedef struct {
        bit          is_rst;
        bit          has_op;
        logic [23:0] addr;
        logic [7:0]  mode;
        int          nbytes;
    } frm_t;

    frm_t        frm_q[$];
    logic [7:0]  exp_q[$];
    bit          bcont = 1'b0;

    always @(posedge clk) cyc++;

    // ---------------- flash model ----------------
    bit          prev_sclk = 0;
    bit          m_act = 0;
    bit          m_cont = 0;
    bit          m_cont_start = 0;
    int          k = 0;
    int          last_j = -1;
    int          dnib = 0;
    int          hi_cnt = 10;
    bit          sclk_bad = 0;
    bit          oe_ok = 1;
    bit          all_high = 1;
    logic [7:0]  m_op = '0;
    logic [23:0] m_addr = '0;
    logic [7:0]  m_mode = '0;

    task automatic on_rise();
        int j;
        all_high = all_high && (io_oe == 4'hF) && (io_o == 4'hF);
        if (!m_cont_start && k < 8) begin
            m_op = {m_op[6:0], io_o[0]};
            if (io_oe[0] !== 1'b1) oe_ok = 0;
            last_j = -1;
        end else begin
            j = k - (m_cont_start ? 0 : 8);
            if (j < 6) begin
                m_addr = {m_addr[19:0], io_o};
                if (io_oe != 4'hF) oe_ok = 0;
            end else if (j < 8) begin
                m_mode = {m_mode[3:0], io_o};
                if (io_oe != 4'hF) oe_ok = 0;
            end else begin
                if (io_oe != 4'h0) oe_ok = 0;
            end
            last_j = j;
        end
        k++;
    endtask

    task automatic on_fall();
        logic [7:0] b;
        if (last_j >= 11) begin
            b = fdat(m_addr + 24'(dnib / 2));
            io_in = dnib[0] ? b[3:0] : b[7:4];
            dnib++;
        end
    endtask

    task automatic end_frame();
        frm_t f;
        int   jend;
        if (frm_q.size() == 0) begin
            chk(0, "R11", "unexpected frame", 1, 0);
        end else begin
            f = frm_q.pop_front();
            if (f.is_rst) begin
                chk(k == 8, "R9", "reset frame clock count", k, 8);
                chk(all_high, "R9", "reset frame lines high", all_high, 1);
            end else begin
                chk(!m_cont_start == f.has_op, "R5", "opcode presence", !m_cont_start, f.has_op);
                if (f.has_op) chk(m_op == 8'hEB, "R2", "opcode", m_op, 8'hEB);
                chk(m_addr == f.addr, "R3", "address", m_addr, f.addr);
                chk(m_mode == f.mode, "R4", "mode byte", m_mode, f.mode);
                chk(oe_ok, "R6", "line direction per phase", oe_ok, 1);
                chk(k == (f.has_op ? 8 : 0) + 12 + 2 * f.nbytes, "R7", "sclk clocks in frame",
                    k, (f.has_op ? 8 : 0) + 12 + 2 * f.nbytes);
            end
        end
        jend = k - (m_cont_start ? 0 : 8);
        if (jend >= 8) m_cont = (m_mode[7:4] == 4'hA);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 0;
            m_act = 0;
            m_cont = 0;
            hi_cnt = 10;
        end else begin
            if (cs_n) begin
                if (sclk) sclk_bad = 1;
                if (m_act) begin
                    end_frame();
                    m_act = 0;
                end
                hi_cnt++;
            end else begin
                if (!m_act) begin
                    m_act = 1;
                    chk(hi_cnt >= 2 && !sclk_bad, "R10", "cs high gap / sclk idle", hi_cnt, 2);
                    chk(!req_ready, "R11", "req_ready low in frame", req_ready, 0);
                    k = 0; last_j = -1; dnib = 0; hi_cnt = 0;
                    m_cont_start = m_cont;
                    m_op = '0; m_addr = '0; m_mode = '0;
                    oe_ok = 1; all_high = 1;
                end
                if (sclk && !prev_sclk) on_rise();
                else if (!sclk && prev_sclk) on_fall();
            end
            prev_sclk = sclk;
        end
    end

    // ---------------- scoreboard monitor ----------------
    bit         held = 0;
    logic [7:0] held_data = '0;

    always @(negedge clk) begin
        if (!rst) begin
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 7) == 0);
            if (held) begin
                chk(out_valid && out_data == held_data, "R8", "held byte stable",
                    {out_valid, out_data}, {1'b1, held_data});
            end
            held = out_valid && !out_ready;
            held_data = out_data;
            if (held && !cs_n && !sclk) stalls++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R7", "read byte", out_data, e);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic wait_accept();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic push_read(input logic [23:0] a, input int n, input bit stay);
        frm_t f;
        f.is_rst = 0;
        f.has_op = !bcont;
        f.addr   = a;
        f.mode   = stay ? 8'hA0 : 8'h00;
        f.nbytes = n;
        frm_q.push_back(f);
        bcont = stay;
        for (int i = 0; i < n; i++) exp_q.push_back(fdat(a + 24'(i)));
    endtask

    task automatic push_rst();
        frm_t f;
        f.is_rst = 1; f.has_op = 0; f.addr = '0; f.mode = '0; f.nbytes = 0;
        frm_q.push_back(f);
        bcont = 0;
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input bit stay);
        push_read(a, n, stay);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_len = LEN_W'(n - 1); req_stay = stay;
        wait_accept();
        req_valid = 0;
    endtask

    task automatic do_mrst();
        push_rst();
        @(negedge clk);
        mrst_valid = 1;
        wait_accept();
        mrst_valid = 0;
    endtask

    task automatic do_both(input logic [23:0] a, input int n, input bit stay);
        push_rst();
        push_read(a, n, stay);
        @(negedge clk);
        mrst_valid = 1; req_valid = 1; req_addr = a; req_len = LEN_W'(n - 1); req_stay = stay;
        wait_accept();
        mrst_valid = 0;
        wait_accept();
        req_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || frm_q.size() != 0 || !cs_n || !req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(cs_n === 1'b1,      "R1", "cs_n", cs_n, 1);
        chk(sclk === 1'b0,      "R1", "sclk", sclk, 0);
        chk(io_oe === 4'h0,     "R1", "io_oe", io_oe, 0);
        chk(out_valid === 1'b0, "R1", "out_valid", out_valid, 0);
        chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);

        do_read(24'h012345, 4, 1'b1);   // R2 opcode, enters mode
        drain();
        do_read(24'h00FFFE, 5, 1'b1);   // R5 no opcode, stays
        drain();
        do_read(24'hABCDEF, 3, 1'b0);   // R5 no opcode, leaves
        drain();
        do_read(24'h100000, 2, 1'b0);   // R5 opcode again
        drain();
        rdy_mode = 1;                   // R8 slow consumer
        do_read(24'h7FFFF0, 10, 1'b1);
        drain();
        chk(stalls > 0, "R8", "sclk paused on waiting byte", stalls, 1);
        rdy_mode = 0;
        do_mrst();                      // R9 reset while in mode
        drain();
        do_read(24'h000010, 2, 1'b1);   // R9 opcode after reset
        drain();
        do_both(24'h345678, 3, 1'b0);   // R11 reset wins, then read
        drain();
        do_read(24'hFFFFFF, 1, 1'b0);   // R7 single byte
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule